// File: doc/BRIEF.md
# Multi-Channel Fractional Tick Generator

This block derives four independent execution tick enables from a single system clock. Each channel owns a fractional divider: a divisor made of a 16-bit integer part and an 8-bit fraction sets the average tick rate, and an accumulator spreads the fractional remainder as jitter between neighbouring integer periods. A small register bus writes the divisors and a shared control word, and reads them back one cycle after a read strobe.

The control word holds a run enable for every channel and two write-one strobe fields. One strobe field emits a one-cycle state-clear pulse to the consumer of a channel. The other re-phases that channel's divider to zero. The dividers never stop, whether or not their channel is enabled. Several channels with the same divisor can therefore be re-phased in one write and then tick in exact lockstep. A start or stop of those channels afterwards does not disturb their alignment.

Each channel drives three outputs: the raw divider tick, the tick gated by the channel's run enable, and the state-clear pulse.

Top module: `frac_tick_bank`

## Requirements
- R1: A write to address 0 loads control bits 0 to 3 as the run enables of channels 0 to 3, all in the same write. The enables keep their value until the next write to address 0.
- R2: Writing a 1 to control bit 4+i makes state_clr[i] high for exactly the one cycle that follows the write edge. At all other times it is low. These bits are not stored.
- R3: Writing a 1 to control bit 8+i sets channel i to phase zero. With D = integer*256 + fraction, raw_tick[i] in the k-th cycle after the write edge (k = 0 first) is 1 exactly when floor((k+1)*256/D) differs from floor(k*256/D).
- R4: An integer part of 0 stands for 65536. With fraction 0 the channel then ticks once every 65536 cycles, first at k = 65535.
- R5: Dividers advance whatever the run enables are. Changes to the enables without a restart leave the R3 tick sequence unchanged.
- R6: tick[i] equals raw_tick[i] AND the run enable of channel i, in the same cycle.
- R7: Channels with equal divisors that are restarted in the same write give identical raw_tick values every cycle afterwards.
- R8: A write to address 1+i loads the divisor of channel i: integer part in wdata[23:8], fraction in wdata[7:0]. It does not re-phase the channel. The divisor reads back at the same address.
- R9: When rd_en is high at a clock edge, rdata shows the addressed register from the next cycle. Address 0 returns the enables in bits 0 to 3 and zero in all other bits. Unused addresses return zero.
- R10: After reset all enables are 0, every divisor is integer 1 with fraction 0, every phase is zero, and state_clr, tick and rdata are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address: 0 control, 1..4 divisors |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| tick | output | 4 | Raw tick gated by the run enable, per channel |
| raw_tick | output | 4 | Free-running divider tick, per channel |
| state_clr | output | 4 | One-cycle state-clear pulse, per channel |

## Verification
A write lands at the clock edge where wr_en is seen. The next cycle is cycle k = 0 of a re-phased divider. The state-clear pulse and the new enables appear in that same cycle, and read data appears in the cycle after a read strobe. The bench drives each stimulus just after an edge and compares every output at the following falling edge. Its per-channel cycle count restarts at the edge that carries a restart bit, and it stops trusting a channel's sequence after a divisor change until that channel is restarted again. Random divisors and enable patterns are combined with directed runs for lockstep, enable toggling and the 65536 period.

// File: rtl/frac_tick_bank.sv
module frac_tick_bank #(
  parameter int NCH = 4,
  parameter int IW  = 16,
  parameter int FW  = 8,
  parameter int ADW = 3,
  parameter int DTW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [ADW-1:0] addr,
  input  logic [DTW-1:0] wdata,
  output logic [DTW-1:0] rdata,
  output logic [NCH-1:0] tick,
  output logic [NCH-1:0] raw_tick,
  output logic [NCH-1:0] state_clr
);
  localparam int DW = IW + FW;
  localparam int AW = DW + 1;
  localparam logic [AW-1:0] STEP = AW'(1) << FW;
  localparam logic [DW-1:0] DIV_RST = DW'(1) << FW;

  logic [NCH-1:0] run_q;
  logic [DW-1:0]  div_q [NCH];
  logic [AW-1:0]  acc_q [NCH];

  wire ctrl_wr = wr_en && (addr == '0);
  wire [NCH-1:0] clr_req = wdata[2*NCH-1:NCH];
  wire [NCH-1:0] rst_req = wdata[3*NCH-1:2*NCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q     <= '0;
      state_clr <= '0;
    end else begin
      state_clr <= ctrl_wr ? clr_req : '0;
      if (ctrl_wr) run_q <= wdata[NCH-1:0];
    end
  end

  assign tick = raw_tick & run_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wire div_wr = wr_en && (addr == ADW'(i + 1));
    wire [AW-1:0] dfull = {div_q[i][DW-1:FW] == '0, div_q[i]};
    wire [AW-1:0] nxt = acc_q[i] + STEP;
    assign raw_tick[i] = nxt >= dfull;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        div_q[i] <= DIV_RST;
        acc_q[i] <= '0;
      end else begin
        if (div_wr) div_q[i] <= wdata[DW-1:0];
        if (ctrl_wr && rst_req[i]) acc_q[i] <= '0;
        else acc_q[i] <= raw_tick[i] ? nxt - dfull : nxt;
      end
    end

    AST_PHASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && rst_req[i]) |=> acc_q[i] == '0);  // R3
    AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && clr_req[i]) |=> state_clr[i]);  // R2
    AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl_wr && clr_req[i]) |=> !state_clr[i]);  // R2
  end

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(run_q));  // R1

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      rdata <= '0;
      if (addr == '0) rdata <= DTW'(run_q);
      for (int j = 0; j < NCH; j++)
        if (addr == ADW'(j + 1)) rdata <= DTW'(div_q[j]);
    end
  end

  AST_RD_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == '0) |=> rdata[DTW-1:NCH] == '0);  // R9
endmodule

// File: tb/frac_tick_bank_test.sv
module frac_tick_bank_test;
  localparam int CLK_NS = 10;

  logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [3:0]  tick, raw_tick, state_clr;

  frac_tick_bank uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tick(tick),
    .raw_tick(raw_tick), .state_clr(state_clr));

  always #(CLK_NS/2) clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [3:0]  m_en = 0;
  logic [3:0]  m_clr = 0;
  logic [23:0] m_reg [4];
  longint      m_k [4];
  bit          m_ok [4];
  bit          rd_due = 0;
  logic [31:0] rd_exp = 0;

  function automatic longint dval(input logic [23:0] r);
    longint ip = (r[23:8] == 0) ? 65536 : longint'(r[23:8]);
    return ip * 256 + longint'(r[7:0]);
  endfunction

  function automatic bit exp_tick(input logic [23:0] r, input longint k);
    longint d = dval(r);
    return ((k + 1) * 256) / d != (k * 256) / d;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit w, input bit r, input logic [2:0] a, input logic [31:0] d);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      if (m_ok[c]) begin
        bit e = exp_tick(m_reg[c], m_k[c]);
        chk(raw_tick[c] == e, "R3/R5 raw_tick", raw_tick[c], e);
        chk(tick[c] == (e & m_en[c]), "R6 tick", tick[c], e & m_en[c]);
      end
    end
    chk(state_clr == m_clr, "R2 state_clr", state_clr, m_clr);
    if (rd_due) chk(rdata == rd_exp, "R9/R8 rdata", rdata, rd_exp);
    @(posedge clk);
    rd_due = r;
    if (r) rd_exp = (a == 0) ? {28'b0, m_en} : (a <= 4) ? {8'b0, m_reg[a-1]} : 32'b0;
    m_clr = (w && a == 0) ? d[7:4] : 4'b0;
    for (int c = 0; c < 4; c++) begin
      if (w && a == 0 && d[8+c]) begin m_k[c] = 0; m_ok[c] = 1; end
      else m_k[c]++;
      if (w && a == 3'(c + 1)) begin m_reg[c] = d[23:0]; m_ok[c] = 0; end
    end
    if (w && a == 0) m_en = d[3:0];
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < 4; c++) begin m_reg[c] = 24'h000100; m_k[c] = 0; m_ok[c] = 1; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk(tick == 0 && state_clr == 0 && rdata == 0, "R10 reset outputs",
        {tick, state_clr}, 0);
    step(0, 1, 0, 0);
    step(0, 1, 1, 0);
    step(0, 0, 0, 0);

    for (int it = 0; it < 8; it++) begin
      for (int c = 0; c < 4; c++) begin
        logic [31:0] dv = {8'b0, 16'($urandom_range(1, 5)), 8'($urandom)};
        step(1, 0, 3'(c + 1), dv);
      end
      step(0, 1, 3'($urandom_range(1, 4)), 0);
      step(1, 0, 0, {20'b0, 4'hF, 4'($urandom), 4'($urandom)});
      idle(40);
      step(0, 1, 0, 0);
      idle(1);
    end

    // R7 lockstep: ch0 and ch1 same divisor, different prior phase
    step(1, 0, 1, 32'h0003_40);
    idle(5);
    step(1, 0, 2, 32'h0003_40);
    step(1, 0, 0, 32'h0000_0300);
    for (int i = 0; i < 50; i++) begin
      step(0, 0, 0, 0);
      chk(raw_tick[0] == raw_tick[1], "R7 lockstep", raw_tick[1:0], {2{raw_tick[0]}});
    end

    // R5 enable toggling without restart keeps phase
    step(1, 0, 3, 32'h0002_a5);
    step(1, 0, 0, 32'h0000_0404);
    idle(13);
    step(1, 0, 0, 32'h0000_0000);
    idle(9);
    step(1, 0, 0, 32'h0000_000f);
    idle(21);

    // R1 multiple enables at once, R2 strobe read back zero
    step(1, 0, 0, 32'h0000_00f5);
    step(0, 1, 0, 0);
    step(0, 1, 7, 0);
    idle(2);

    // R4 integer 0 means 65536
    step(1, 0, 4, 32'h0000_0000);
    step(1, 0, 0, 32'h0000_0808);
    idle(65540);

    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule